// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display pipe: horizontal sync, vertical sync, an active-video window, a one-cycle pulse when the active rows end, and a one-cycle pulse on a programmable line for the interrupt unit. All positions are absolute edges measured from the start of the line or frame, not widths. Software loads them through a simple write-only 32-bit register port. Each horizontal unit lasts a number of pixel clocks set by the clock divisor input.

Vertical positions count half-lines. With interlace off, the vertical counter steps by two per line. With interlace on, it steps by one per line. Register writes go into a shadow set, and the shadow set is copied into the live set at the frame boundary. A frame therefore always runs with a single consistent geometry.

A three-state machine tracks the vertical region: `V_TOP` is the blank rows before active video, `V_ACTIVE` is the visible rows, and `V_BOTTOM` is the blank rows after active video. The transitions are:
- TOP→ACTIVE ("open"): a line start reaches the active-start row.
- TOP→BOTTOM ("skip"): no line falls inside the active rows.
- ACTIVE→BOTTOM ("close"): the first line at or past the active-end row. This transition raises the blank pulse.
- ACTIVE/BOTTOM→TOP or ACTIVE ("restart"): the frame wraps. The state is then set from row 0 under the newly loaded geometry.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, the live and shadow geometry equal the parameter defaults and both counters are zero. Both pulse outputs are low. With the defaults, hsync and vsync are high and active is low.
- R2: A write to byte offset 0x290 + 16*i with i in 0..16 lands in timing slot i. The slots that are used are: 0 hsync width, 3 line total, 7 active start, 8 active end, 10 vsync width in half-lines, 11 frame total in half-lines, 14 active start row, 15 active end row. A write to 0x260 sets the cursor row. Bits 11:0 of the write data carry the value.
- R3: A line lasts (line total) × D clock cycles, where D is the clock divisor and a divisor of 0 counts as 1.
- R4: hsync is high for the first (hsync width) × D cycles of every line.
- R5: active is high when the horizontal unit count is in [active start, active end) and the half-line count is in [active start row, active end row).
- R6: The half-line count starts each frame at 0 and steps by 2 per line with interlace low, or by 1 with interlace high. The frame wraps when the next value would reach the frame total, so a frame has ceil(total/step) lines.
- R7: vsync is high for every line whose half-line count is below the vsync width.
- R8: vblank_pulse is high for exactly one cycle, at the start of the first line at or past the active end row after an active line. At most one such pulse occurs per frame.
- R9: cursor_pulse is high for one cycle at the start of the line whose half-line count equals the cursor row. There is at most one such pulse per frame, and none if no line has that count.
- R10: A register write changes nothing in the current frame and takes effect from the next frame start.
- R11: Writes to unused slots, to offsets not aligned to 16, to offsets beyond slot 16 or to any other address have no effect on timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| clk_div | input | 4 | Pixel clocks per horizontal unit (0 acts as 1) |
| interlace | input | 1 | 1: vertical count steps by one per line |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| active | output | 1 | Active-video window |
| vblank_pulse | output | 1 | One-cycle pulse at the end of active rows |
| cursor_pulse | output | 1 | One-cycle pulse on the cursor row |

## Verification
The checker tests several properties on every cycle:
- The horizontal count stays below the line total.
- The vertical count only moves when a line starts.
- The blank pulse never lasts two cycles and only appears at or past the active-end row.
- The cursor pulse only appears on the programmed row at a line start.
- active is never high outside the active rows.

Only the bench scenarios can show the rest. These are the exact line and frame lengths under each divisor and interlace setting, the sync widths, the active cycle count, and the pulse counts and positions within a frame. They also include the frame-deferred effect of writes and the fact that stray offsets are ignored.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int TW        = 12;
    localparam int NUM_SLOTS = 17;

    localparam int SLOT_HSW  = 0;
    localparam int SLOT_HTOT = 3;
    localparam int SLOT_HBEG = 7;
    localparam int SLOT_HEND = 8;
    localparam int SLOT_VSW  = 10;
    localparam int SLOT_VTOT = 11;
    localparam int SLOT_VBEG = 14;
    localparam int SLOT_VEND = 15;

    typedef enum logic [1:0] {
        V_TOP    = 2'd0,
        V_ACTIVE = 2'd1,
        V_BOTTOM = 2'd2
    } vregion_e;

    typedef struct packed {
        logic [TW-1:0] h_total;
        logic [TW-1:0] h_sync_w;
        logic [TW-1:0] h_act_beg;
        logic [TW-1:0] h_act_end;
        logic [TW-1:0] v_total;
        logic [TW-1:0] v_sync_w;
        logic [TW-1:0] v_act_beg;
        logic [TW-1:0] v_act_end;
        logic [TW-1:0] cur_line;
    } timing_t;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int      ADDR_W      = 12,
    parameter int      DATA_W      = 32,
    parameter int      SLOT_BASE   = 'h290,
    parameter int      STRIDE_LOG2 = 4,
    parameter int      CUR_ADDR    = 'h260,
    parameter timing_t RST_CFG     = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              frame_load,
    output timing_t           cur_cfg,
    output timing_t           next_cfg
);

    localparam int SLOT_W = $clog2(NUM_SLOTS);

    timing_t           shadow_q;
    timing_t           live_q;
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] slot_full;
    logic [SLOT_W-1:0] slot;
    logic              hit_slot;
    logic              hit_cur;
    logic [TW-1:0]     field;
    logic              unused_wdata_hi;

    always_comb begin
        rel       = reg_addr - ADDR_W'(SLOT_BASE);
        slot_full = rel >> STRIDE_LOG2;
        slot      = slot_full[SLOT_W-1:0];
        hit_slot  = reg_wr
                 && (reg_addr >= ADDR_W'(SLOT_BASE))
                 && (slot_full < ADDR_W'(NUM_SLOTS))
                 && (rel[STRIDE_LOG2-1:0] == '0);
        hit_cur   = reg_wr && (reg_addr == ADDR_W'(CUR_ADDR));
        field     = reg_wdata[TW-1:0];
    end

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:TW];

    // Shadow set: written by software at any time.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= RST_CFG;
        end else begin
            if (hit_slot) begin
                case (slot)
                    SLOT_W'(SLOT_HSW):  shadow_q.h_sync_w  <= field;
                    SLOT_W'(SLOT_HTOT): shadow_q.h_total   <= field;
                    SLOT_W'(SLOT_HBEG): shadow_q.h_act_beg <= field;
                    SLOT_W'(SLOT_HEND): shadow_q.h_act_end <= field;
                    SLOT_W'(SLOT_VSW):  shadow_q.v_sync_w  <= field;
                    SLOT_W'(SLOT_VTOT): shadow_q.v_total   <= field;
                    SLOT_W'(SLOT_VBEG): shadow_q.v_act_beg <= field;
                    SLOT_W'(SLOT_VEND): shadow_q.v_act_end <= field;
                    default: ;
                endcase
            end
            if (hit_cur) begin
                shadow_q.cur_line <= field;
            end
        end
    end

    // Live set: copied only at the frame boundary.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= RST_CFG;
        end else if (frame_load) begin
            live_q <= shadow_q;
        end
    end

    assign cur_cfg  = live_q;
    assign next_cfg = frame_load ? shadow_q : live_q;

endmodule

// File: rtl/rtg_hcount.sv
module rtg_hcount
    import rtg_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [TW-1:0]    h_total,
    output logic [TW-1:0]    hcnt,
    output logic             line_end
);

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] lim;
    logic [DIV_W:0]   pre_inc;
    logic [TW:0]      h_inc;
    logic             tick;
    logic             last_unit;

    always_comb begin
        lim       = (clk_div == '0) ? DIV_W'(1) : clk_div;
        pre_inc   = {1'b0, pre_q} + (DIV_W+1)'(1);
        tick      = pre_inc >= {1'b0, lim};
        h_inc     = {1'b0, hcnt} + (TW+1)'(1);
        last_unit = h_inc >= {1'b0, h_total};
        line_end  = tick && last_unit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            hcnt  <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_inc[DIV_W-1:0];
            if (tick) begin
                hcnt <= last_unit ? '0 : h_inc[TW-1:0];
            end
        end
    end

endmodule

// File: rtl/rtg_vfsm.sv
module rtg_vfsm
    import rtg_pkg::*;
#(
    parameter timing_t RST_CFG = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic          interlace,
    input  logic [TW-1:0] hcnt,
    input  timing_t       cur_cfg,
    input  timing_t       next_cfg,
    output logic          frame_load,
    output logic [TW-1:0] vcnt,
    output vregion_e      vstate,
    output logic          hsync,
    output logic          vsync,
    output logic          active,
    output logic          vblank_pulse,
    output logic          cursor_pulse
);

    function automatic vregion_e region_of(input logic [TW-1:0] v, input timing_t c);
        if (v < c.v_act_beg) begin
            return V_TOP;
        end else if (v < c.v_act_end) begin
            return V_ACTIVE;
        end
        return V_BOTTOM;
    endfunction

    localparam vregion_e RST_STATE = region_of('0, RST_CFG);

    logic [TW:0]   step;
    logic [TW:0]   v_sum;
    logic          wrap;
    logic [TW-1:0] v_nxt;
    vregion_e      reg_nxt;
    vregion_e      state_nxt;
    logic          close_evt;
    logic          cursor_evt;

    always_comb begin
        step       = interlace ? (TW+1)'(1) : (TW+1)'(2);
        v_sum      = {1'b0, vcnt} + step;
        wrap       = line_end && (v_sum >= {1'b0, cur_cfg.v_total});
        frame_load = wrap;
        if (!line_end) begin
            v_nxt = vcnt;
        end else if (wrap) begin
            v_nxt = '0;
        end else begin
            v_nxt = v_sum[TW-1:0];
        end
        reg_nxt    = region_of(v_nxt, next_cfg);
        state_nxt  = vstate;
        close_evt  = 1'b0;
        unique case (vstate)
            V_TOP: begin
                // open or skip
                if (line_end) begin
                    state_nxt = reg_nxt;
                end
            end
            V_ACTIVE: begin
                // close (no wrap) or restart (wrap)
                if (line_end && (wrap || reg_nxt == V_BOTTOM)) begin
                    state_nxt = reg_nxt;
                    close_evt = !wrap;
                end
            end
            V_BOTTOM: begin
                // restart
                if (wrap) begin
                    state_nxt = reg_nxt;
                end
            end
            default: state_nxt = V_TOP;
        endcase
        cursor_evt = line_end && (v_nxt == next_cfg.cur_line);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vstate <= RST_STATE;
            vcnt   <= '0;
        end else begin
            vstate <= state_nxt;
            vcnt   <= v_nxt;
        end
    end

    // Pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vblank_pulse <= 1'b0;
            cursor_pulse <= 1'b0;
        end else begin
            vblank_pulse <= close_evt;
            cursor_pulse <= cursor_evt;
        end
    end

    // Level outputs
    always_comb begin
        hsync  = hcnt < cur_cfg.h_sync_w;
        vsync  = vcnt < cur_cfg.v_sync_w;
        active = (vstate == V_ACTIVE)
              && (hcnt >= cur_cfg.h_act_beg)
              && (hcnt <  cur_cfg.h_act_end);
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int DIV_W    = 4,
    parameter int DEF_HTOT = 8,
    parameter int DEF_HSW  = 1,
    parameter int DEF_HBEG = 2,
    parameter int DEF_HEND = 7,
    parameter int DEF_VTOT = 12,
    parameter int DEF_VSW  = 2,
    parameter int DEF_VBEG = 2,
    parameter int DEF_VEND = 10,
    parameter int DEF_CUR  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              interlace,
    output logic              hsync,
    output logic              vsync,
    output logic              active,
    output logic              vblank_pulse,
    output logic              cursor_pulse
);

    localparam timing_t RST_CFG = '{
        h_total:   TW'(DEF_HTOT),
        h_sync_w:  TW'(DEF_HSW),
        h_act_beg: TW'(DEF_HBEG),
        h_act_end: TW'(DEF_HEND),
        v_total:   TW'(DEF_VTOT),
        v_sync_w:  TW'(DEF_VSW),
        v_act_beg: TW'(DEF_VBEG),
        v_act_end: TW'(DEF_VEND),
        cur_line:  TW'(DEF_CUR)
    };

    timing_t       cur_cfg;
    timing_t       next_cfg;
    logic          frame_load;
    logic          line_end;
    logic [TW-1:0] hcnt;
    logic [TW-1:0] vcnt;
    vregion_e      vstate;

    rtg_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RST_CFG (RST_CFG)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .frame_load (frame_load),
        .cur_cfg    (cur_cfg),
        .next_cfg   (next_cfg)
    );

    rtg_hcount #(
        .DIV_W (DIV_W)
    ) u_hcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_div  (clk_div),
        .h_total  (cur_cfg.h_total),
        .hcnt     (hcnt),
        .line_end (line_end)
    );

    rtg_vfsm #(
        .RST_CFG (RST_CFG)
    ) u_vfsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_end     (line_end),
        .interlace    (interlace),
        .hcnt         (hcnt),
        .cur_cfg      (cur_cfg),
        .next_cfg     (next_cfg),
        .frame_load   (frame_load),
        .vcnt         (vcnt),
        .vstate       (vstate),
        .hsync        (hsync),
        .vsync        (vsync),
        .active       (active),
        .vblank_pulse (vblank_pulse),
        .cursor_pulse (cursor_pulse)
    );

endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk
    import rtg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] hcnt,
    input logic [TW-1:0] vcnt,
    input logic [TW-1:0] h_total,
    input logic [TW-1:0] v_beg,
    input logic [TW-1:0] v_end,
    input logic [TW-1:0] cur_line,
    input logic          active,
    input logic          vblank_pulse,
    input logic          cursor_pulse
);

    assert_hcnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == '0) || (hcnt < h_total));

    assert_vcnt_at_line_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vcnt) |-> (hcnt == '0));

    assert_active_rows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((vcnt >= v_beg) && (vcnt < v_end)));

    assert_vblank_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_pulse |=> !vblank_pulse);

    assert_vblank_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_pulse |-> ((vcnt >= v_end) && (hcnt == '0)));

    assert_cursor_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_pulse |-> ((vcnt == cur_line) && (hcnt == '0)));

endmodule

bind raster_timing_gen raster_timing_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hcnt         (hcnt),
    .vcnt         (vcnt),
    .h_total      (cur_cfg.h_total),
    .v_beg        (cur_cfg.v_act_beg),
    .v_end        (cur_cfg.v_act_end),
    .cur_line     (cur_cfg.cur_line),
    .active       (active),
    .vblank_pulse (vblank_pulse),
    .cursor_pulse (cursor_pulse)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  clk_div = 4'd1;
    logic        interlace = 1'b0;
    logic        hsync, vsync, active, vblank_pulse, cursor_pulse;

    always #10 clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .clk_div      (clk_div),
        .interlace    (interlace),
        .hsync        (hsync),
        .vsync        (vsync),
        .active       (active),
        .vblank_pulse (vblank_pulse),
        .cursor_pulse (cursor_pulse)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int g_ht, g_hsw, g_hal, g_hfp, g_vt, g_vsw, g_val, g_vfp, g_cur;
    int m_len, m_hs, m_vs, m_act, m_vb, m_vboff, m_cu, m_cuoff;
    int e_len, e_hs, e_vs, e_act, e_vb, e_vboff, e_cu, e_cuoff;

    task automatic chk(input string req, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [11:0] a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic program_all();
        wr(12'h2C0, g_ht);  wr(12'h290, g_hsw); wr(12'h300, g_hal);
        wr(12'h310, g_hfp); wr(12'h340, g_vt);  wr(12'h330, g_vsw);
        wr(12'h370, g_val); wr(12'h380, g_vfp); wr(12'h260, g_cur);
    endtask

    task automatic wait_rise();
        logic p;
        p = vsync;
        forever begin
            @(negedge clk);
            if (vsync && !p) break;
            p = vsync;
        end
    endtask

    // Starts on the sample where vsync has just risen; ends on the next such sample.
    task automatic measure(input bit do_wr, input logic [11:0] a, input int d);
        logic p;
        int i;
        m_len = 0; m_hs = 0; m_vs = 0; m_act = 0;
        m_vb = 0; m_vboff = -1; m_cu = 0; m_cuoff = -1;
        i = 0;
        while (i < 4000) begin
            if (hsync) m_hs++;
            if (vsync) m_vs++;
            if (active) m_act++;
            if (vblank_pulse) begin m_vb++; m_vboff = i; end
            if (cursor_pulse) begin m_cu++; m_cuoff = i; end
            if (do_wr && i == 3) begin
                reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
            end
            if (i == 4) reg_wr = 1'b0;
            p = vsync;
            @(negedge clk);
            i++;
            if (vsync && !p) break;
        end
        m_len = i;
    endtask

    task automatic expect_frame();
        int dd, st, nl, cyc, nact, hsw;
        dd  = (clk_div == 0) ? 1 : int'(clk_div);
        st  = interlace ? 1 : 2;
        nl  = (g_vt + st - 1) / st;
        cyc = g_ht * dd;
        hsw = (g_hsw < g_ht) ? g_hsw : g_ht;
        e_len = nl * cyc; e_hs = nl * hsw * dd;
        e_vs = 0; nact = 0; e_vb = 0; e_vboff = -1; e_cu = 0; e_cuoff = -1;
        for (int k = 0; k < nl; k++) begin
            int v, pv;
            v  = k * st;
            pv = (k - 1) * st;
            if (v < g_vsw) e_vs += cyc;
            if (v >= g_val && v < g_vfp) nact++;
            if (k > 0 && v >= g_vfp && pv >= g_val && pv < g_vfp) begin
                e_vb++; e_vboff = k * cyc;
            end
            if (v == g_cur) begin e_cu++; e_cuoff = k * cyc; end
        end
        e_act = nact * (g_hfp - g_hal) * dd;
    endtask

    task automatic set_geo(input int g);
        case (g)
            0: begin g_ht=8; g_hsw=1; g_hal=2; g_hfp=7; g_vt=12; g_vsw=2; g_val=2; g_vfp=10; g_cur=4; end
            1: begin g_ht=5; g_hsw=2; g_hal=0; g_hfp=5; g_vt=9;  g_vsw=3; g_val=1; g_vfp=6;  g_cur=3; end
            default: begin g_ht=6; g_hsw=3; g_hal=1; g_hfp=4; g_vt=7; g_vsw=1; g_val=0; g_vfp=4; g_cur=0; end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with default geometry
        repeat (3) @(negedge clk);
        chk("R1 hsync in reset", int'(hsync), 1);
        chk("R1 vsync in reset", int'(vsync), 1);
        chk("R1 active in reset", int'(active), 0);
        chk("R1 vblank_pulse in reset", int'(vblank_pulse), 0);
        chk("R1 cursor_pulse in reset", int'(cursor_pulse), 0);
        rst_n = 1'b1;

        // Default geometry frame, divisor 1, progressive (R1 defaults = geometry 0)
        set_geo(0);
        wait_rise();
        measure(0, '0, 0);
        expect_frame();
        chk("R1 default frame length", m_len, e_len);

        // Sweep: geometry x divisor x interlace (R2..R9)
        for (int g = 0; g < 3; g++) begin
            for (int d = 0; d < 4; d++) begin
                for (int il = 0; il < 2; il++) begin
                    set_geo(g);
                    @(negedge clk);
                    clk_div = 4'(d);
                    interlace = il[0];
                    program_all();
                    wait_rise();
                    wait_rise();
                    measure(0, '0, 0);
                    expect_frame();
                    chk("R3 R6 R2 frame length", m_len, e_len);
                    chk("R4 hsync cycles", m_hs, e_hs);
                    chk("R7 vsync cycles", m_vs, e_vs);
                    chk("R5 active cycles", m_act, e_act);
                    chk("R8 vblank count", m_vb, e_vb);
                    chk("R8 vblank offset", m_vboff, e_vboff);
                    chk("R9 cursor count", m_cu, e_cu);
                    chk("R9 cursor offset", m_cuoff, e_cuoff);
                end
            end
        end

        // R10: writes are deferred to the next frame
        set_geo(0);
        @(negedge clk);
        clk_div = 4'd1;
        interlace = 1'b0;
        program_all();
        wait_rise();
        wait_rise();
        measure(1, 12'h2C0, 10);
        chk("R10 current frame unchanged", m_len, 48);
        measure(1, 12'h2C0, 8);
        chk("R10 next frame uses new total", m_len, 60);
        measure(1, 12'h2A0, 3);
        chk("R10 restored total next frame", m_len, 48);

        // R11: stray writes have no effect
        measure(1, 12'h2C4, 3);
        chk("R11 unused slot 0x2A0 ignored", m_len, 48);
        measure(1, 12'h3A0, 3);
        chk("R11 misaligned 0x2C4 ignored", m_len, 48);
        measure(1, 12'h250, 3);
        chk("R11 slot past end 0x3A0 ignored", m_len, 48);
        measure(0, '0, 0);
        chk("R11 other offset 0x250 ignored", m_len, 48);
        chk("R11 active cycles unchanged", m_act, 4 * 5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule